// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block sits beside the control path of a small 32-bit processor core. It takes seven exception request lines, the current program counter and the current status word. In one clock cycle it chooses the most urgent request that is not masked. It then produces the handler address, the status word for the handler mode, the status copy saved for that mode and the link value. A one-cycle entry pulse tells the core to load all of these. The core owns the live status word and feeds it back on `cur_status`. This block keeps one saved status copy for each exception mode.

The block also handles two control commands. An exception-return command restores the status word from the saved copy of the current mode and loads the PC from a link value supplied by the core. A mode-write command replaces the mode field, but only from a privileged mode. When an exception and a command arrive in the same cycle, the exception wins.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several unmasked requests are present, exactly one is taken. The order, most urgent first, is: reset, data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt, undefined instruction.
- R2: On entry, `new_pc` holds the handler address for the chosen source:
  - reset 0x00
  - undefined instruction 0x04
  - software interrupt 0x08
  - prefetch abort 0x0C
  - data abort 0x10
  - normal interrupt 0x18
  - fast interrupt 0x1C
- R3: On entry, bits [4:0] of `new_status` hold the handler mode:
  - supervisor 10011 for reset and software interrupt
  - abort 10111 for both aborts
  - fast 10001
  - normal 10010
  - undefined 11011
  - User is 10000 and System is 11111.
- R4: On entry, `saved_status` equals the `cur_status` sampled at that edge, and the same value is stored as the saved copy of the handler mode.
- R5: Every entry sets bit 7 (normal-interrupt disable) and clears bit 5 (instruction-set state). All bits above bit 7 are kept.
- R6: Bit 6 (fast-interrupt disable) is set on entry only for fast interrupt and reset. Otherwise it keeps its value from `cur_status`.
- R7: A normal interrupt request is ignored while `cur_status` bit 7 is 1. A fast interrupt request is ignored while bit 6 is 1. Aborts, software interrupt, undefined instruction and reset are never masked.
- R8: When software interrupt and undefined instruction are requested together with nothing more urgent, software interrupt is taken (handler address 0x08).
- R9: An entry is visible one clock after the request is sampled. At that point `entry_pulse`, `pc_load` and `status_load` are 1 and `link_val` equals the sampled `cur_pc`. `entry_pulse` falls in the next cycle if no request remains.
- R10: The return command in a mode with a saved copy (fast, normal, supervisor, abort, undefined) sets `new_status` to that copy and `new_pc` to `ret_link`, with `pc_load` and `status_load` 1. In User or System mode the command is ignored (no load).
- R11: A mode write in any mode other than User sets `new_status` to `cur_status` with bits [4:0] replaced, and raises `status_load` without `pc_load`. It is ignored in User mode and ignored for any value outside the seven legal encodings.
- R12: Precedence is exception entry, then return, then mode write. A pending return command blocks a mode write in the same cycle.
- R13: While `rst_n` is low, all outputs are driven to zero at the clock edge and all saved copies are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_dabort | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_undef | input | 1 | Undefined instruction request |
| cur_pc | input | XLEN | PC of the faulting or next instruction |
| cur_status | input | XLEN | Live status word from the core |
| ret_cmd | input | 1 | Exception-return command |
| ret_link | input | XLEN | Return address for the return command |
| mode_wr_en | input | 1 | Mode-field write command |
| mode_wr_val | input | 5 | Mode encoding to write |
| new_pc | output | XLEN | PC to load (handler address or return address) |
| new_status | output | XLEN | Status word to load |
| saved_status | output | XLEN | Status copy saved at the last entry |
| link_val | output | XLEN | Link value captured at the last entry |
| entry_pulse | output | 1 | One-cycle marker of an exception entry |
| pc_load | output | 1 | `new_pc` is to be loaded this cycle |
| status_load | output | 1 | `new_status` is to be loaded this cycle |

## Verification
The properties assume that `cur_status` carries one of the seven legal mode encodings in bits [4:0]. They also assume the core keeps the status word coherent with the loads this block orders. The masking properties further assume that no more urgent request is present in the same cycle. The stimulus meets these assumptions by applying only handcrafted status words with legal modes. Each request pattern is held for exactly one sampled edge. Commands are combined with requests only in the precedence test, where the expected winner is stated explicitly.

// File: rtl/exc_pkg.sv
// Shared definitions for the exception entry controller.
// Assumes the status word places the mode in [4:0], the
// instruction-set state in bit 5, fast-interrupt disable in bit 6
// and normal-interrupt disable in bit 7.
package exc_pkg;

    localparam int NUM_SRC  = 7;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int NUM_BANK = 5;
    localparam int BANK_W   = $clog2(NUM_BANK);
    localparam int MODE_W   = 5;
    localparam int BIT_T    = 5;
    localparam int BIT_F    = 6;
    localparam int BIT_I    = 7;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    // Source index equals urgency rank, 0 is the most urgent.
    typedef enum logic [SRC_W-1:0] {
        SRC_RST  = 3'd0,
        SRC_DABT = 3'd1,
        SRC_FIQ  = 3'd2,
        SRC_IRQ  = 3'd3,
        SRC_PABT = 3'd4,
        SRC_SWI  = 3'd5,
        SRC_UND  = 3'd6
    } src_e;

    // Handler offsets from the vector base.
    localparam logic [7:0] VOFF_RST  = 8'h00;
    localparam logic [7:0] VOFF_UND  = 8'h04;
    localparam logic [7:0] VOFF_SWI  = 8'h08;
    localparam logic [7:0] VOFF_PABT = 8'h0C;
    localparam logic [7:0] VOFF_DABT = 8'h10;
    localparam logic [7:0] VOFF_IRQ  = 8'h18;
    localparam logic [7:0] VOFF_FIQ  = 8'h1C;

    // True for the seven legal mode encodings.
    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

    // True for modes that own a saved status copy.
    function automatic logic mode_has_bank(input logic [MODE_W-1:0] m);
        case (m)
            M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    // Saved-copy slot of a mode; meaningful only when mode_has_bank.
    function automatic logic [BANK_W-1:0] mode_bank(input logic [MODE_W-1:0] m);
        case (m)
            M_FIQ:   return BANK_W'(0);
            M_IRQ:   return BANK_W'(1);
            M_SVC:   return BANK_W'(2);
            M_ABT:   return BANK_W'(3);
            M_UND:   return BANK_W'(4);
            default: return BANK_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Fixed-rank request picker.
// Does: removes masked requests and reports the lowest-index survivor.
// Assumes: index 0 is the most urgent; purely combinational.
module exc_arbiter #(
    parameter int N     = 7,
    localparam int SELW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N-1:0]    mask,
    output logic            hit,
    output logic [SELW-1:0] sel
);

    logic [N-1:0] live;

    // Strip masked sources.
    assign live = req & ~mask;
    assign hit  = |live;

    // Scan from least to most urgent so the most urgent survivor wins.
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) sel = SELW'(i);
        end
    end

endmodule

// File: rtl/exc_vector_map.sv
// Per-source handler parameters.
// Does: maps a source index to handler address, handler mode and
// whether the fast-interrupt disable must be forced.
// Assumes: sel holds a legal source index; combinational.
module exc_vector_map
    import exc_pkg::*;
#(
    parameter int XLEN                 = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic [SRC_W-1:0]  sel,
    output logic [XLEN-1:0]   vec,
    output logic [MODE_W-1:0] tgt_mode,
    output logic              set_f
);

    logic [7:0] voff;

    // Decode offset, mode and fast-disable per source.
    always_comb begin
        voff     = VOFF_RST;
        tgt_mode = M_SVC;
        set_f    = 1'b0;
        case (src_e'(sel))
            SRC_RST:  begin voff = VOFF_RST;  tgt_mode = M_SVC; set_f = 1'b1; end
            SRC_DABT: begin voff = VOFF_DABT; tgt_mode = M_ABT; end
            SRC_FIQ:  begin voff = VOFF_FIQ;  tgt_mode = M_FIQ; set_f = 1'b1; end
            SRC_IRQ:  begin voff = VOFF_IRQ;  tgt_mode = M_IRQ; end
            SRC_PABT: begin voff = VOFF_PABT; tgt_mode = M_ABT; end
            SRC_SWI:  begin voff = VOFF_SWI;  tgt_mode = M_SVC; end
            SRC_UND:  begin voff = VOFF_UND;  tgt_mode = M_UND; end
            default:  begin voff = VOFF_RST;  tgt_mode = M_SVC; end
        endcase
    end

    // Handler address is base plus offset.
    assign vec = VEC_BASE + XLEN'(voff);

endmodule

// File: rtl/exc_saved_bank.sv
// Saved status storage, one register per exception mode.
// Does: writes one slot per cycle, reads one slot combinationally.
// Assumes: synchronous active-low reset clears every slot.
module exc_saved_bank #(
    parameter int XLEN  = 32,
    parameter int NB    = 5,
    localparam int IDXW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [XLEN-1:0] rd_data
);

    logic [XLEN-1:0] slot_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_slot
        // Capture the status copy into this slot when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                slot_q[g] <= '0;
            else if (wr_en && (wr_idx == IDXW'(g)))    slot_q[g] <= wr_data;
        end
    end

    // Read mux, zero for an index beyond the slot count.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NB; i++) begin
            if (rd_idx == IDXW'(i)) rd_data = slot_q[i];
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception priority and entry controller (top).
// Does: picks the most urgent unmasked exception, orders a PC and
// status load, keeps per-mode saved status copies, and serves the
// return and mode-write commands. All outputs are registered.
// Assumes: the core owns the live status word and presents it on
// cur_status; requests are sampled every rising edge.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN                 = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_dabort,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabort,
    input  logic              req_swi,
    input  logic              req_undef,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_status,
    input  logic              ret_cmd,
    input  logic [XLEN-1:0]   ret_link,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_val,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_status,
    output logic [XLEN-1:0]   saved_status,
    output logic [XLEN-1:0]   link_val,
    output logic              entry_pulse,
    output logic              pc_load,
    output logic              status_load
);

    logic [NUM_SRC-1:0] req_v;
    logic [NUM_SRC-1:0] mask_v;
    logic               hit;
    logic [SRC_W-1:0]   sel;
    logic [XLEN-1:0]    vec;
    logic [MODE_W-1:0]  tgt_mode;
    logic               set_f;
    logic [MODE_W-1:0]  cur_mode;
    logic [XLEN-1:0]    ent_status;
    logic [XLEN-1:0]    wr_status;
    logic [XLEN-1:0]    bank_rd;
    logic               ret_go;
    logic               wr_go;

    // Requests in urgency order, bit index equals rank.
    assign req_v = {req_undef, req_swi, req_pabort, req_irq,
                    req_fiq, req_dabort, req_reset};

    // Only the two interrupt lines can be masked.
    always_comb begin
        mask_v           = '0;
        mask_v[SRC_FIQ]  = cur_status[BIT_F];
        mask_v[SRC_IRQ]  = cur_status[BIT_I];
    end

    assign cur_mode = cur_status[MODE_W-1:0];

    exc_arbiter #(.N(NUM_SRC)) u_arb (
        .req  (req_v),
        .mask (mask_v),
        .hit  (hit),
        .sel  (sel)
    );

    exc_vector_map #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_map (
        .sel      (sel),
        .vec      (vec),
        .tgt_mode (tgt_mode),
        .set_f    (set_f)
    );

    exc_saved_bank #(.XLEN(XLEN), .NB(NUM_BANK)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit),
        .wr_idx  (mode_bank(tgt_mode)),
        .wr_data (cur_status),
        .rd_idx  (mode_bank(cur_mode)),
        .rd_data (bank_rd)
    );

    // Build the handler status word from the live one.
    always_comb begin
        ent_status                 = cur_status;
        ent_status[BIT_I]          = 1'b1;
        ent_status[BIT_T]          = 1'b0;
        ent_status[BIT_F]          = cur_status[BIT_F] | set_f;
        ent_status[MODE_W-1:0]     = tgt_mode;
    end

    // Status word for a privileged mode write.
    always_comb begin
        wr_status              = cur_status;
        wr_status[MODE_W-1:0]  = mode_wr_val;
    end

    // Command qualification with entry > return > mode write.
    assign ret_go = !hit && ret_cmd && mode_has_bank(cur_mode);
    assign wr_go  = !hit && !ret_cmd && mode_wr_en &&
                    (cur_mode != M_USR) && mode_legal(mode_wr_val);

    // Output registers and load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc       <= '0;
            new_status   <= '0;
            saved_status <= '0;
            link_val     <= '0;
            entry_pulse  <= 1'b0;
            pc_load      <= 1'b0;
            status_load  <= 1'b0;
        end else begin
            entry_pulse <= hit;
            pc_load     <= hit | ret_go;
            status_load <= hit | ret_go | wr_go;
            if (hit) begin
                new_pc       <= vec;
                new_status   <= ent_status;
                saved_status <= cur_status;
                link_val     <= cur_pc;
            end else if (ret_go) begin
                new_pc     <= ret_link;
                new_status <= bank_rd;
            end else if (wr_go) begin
                new_status <= wr_status;
            end
        end
    end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Property checker for exc_entry_ctrl, attached by bind.
// Does: checks entry, masking and command rules at the ports.
// Assumes: cur_status always carries a legal mode encoding.
module exc_entry_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_reset,
    input logic            req_dabort,
    input logic            req_fiq,
    input logic            req_irq,
    input logic            req_pabort,
    input logic            req_swi,
    input logic            req_undef,
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] cur_status,
    input logic            ret_cmd,
    input logic            mode_wr_en,
    input logic [XLEN-1:0] new_pc,
    input logic [XLEN-1:0] new_status,
    input logic [XLEN-1:0] saved_status,
    input logic [XLEN-1:0] link_val,
    input logic            entry_pulse,
    input logic            pc_load,
    input logic            status_load
);

    logic any_req;
    assign any_req = req_reset | req_dabort | req_fiq | req_irq |
                     req_pabort | req_swi | req_undef;

    p_reset_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |=> (entry_pulse && new_pc == '0 && new_status[4:0] == 5'b10011));

    p_swi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_swi && req_undef && !req_reset && !req_dabort && !req_pabort &&
         !(req_fiq && !cur_status[6]) && !(req_irq && !cur_status[7]))
        |=> (new_pc == XLEN'(8)));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_irq && cur_status[7] && !req_reset && !req_dabort && !req_fiq &&
         !req_pabort && !req_swi && !req_undef) |=> !entry_pulse);

    p_fiq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fiq && cur_status[6] && !req_reset && !req_dabort && !req_irq &&
         !req_pabort && !req_swi && !req_undef) |=> !entry_pulse);

    p_i_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (new_status[7] && !new_status[5]));

    p_f_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && new_pc != '0 && new_pc != XLEN'(32'h1C))
        |-> (new_status[6] == $past(cur_status[6])));

    p_saved_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (saved_status == $past(cur_status)));

    p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (link_val == $past(cur_pc) && pc_load && status_load));

    p_user_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en && !ret_cmd && !any_req && cur_status[4:0] == 5'b10000)
        |=> !status_load);

    p_entry_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_dabort && ret_cmd) |=> entry_pulse);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 0, req_dabort = 0, req_fiq = 0, req_irq = 0;
    logic        req_pabort = 0, req_swi = 0, req_undef = 0;
    logic [31:0] cur_pc = '0, cur_status = '0, ret_link = '0;
    logic        ret_cmd = 0, mode_wr_en = 0;
    logic [4:0]  mode_wr_val = '0;
    logic [31:0] new_pc, new_status, saved_status, link_val;
    logic        entry_pulse, pc_load, status_load;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl u0 (.*);

    // Row: {req r,d,f,i,p,s,u (7), status (32), hit (1), pc (8), exp status (32)}
    localparam logic [79:0] VT [0:18] = '{
        {7'b1000000, 32'h60000010, 1'b1, 8'h00, 32'h600000D3},
        {7'b0100000, 32'h60000010, 1'b1, 8'h10, 32'h60000097},
        {7'b0010000, 32'h60000010, 1'b1, 8'h1C, 32'h600000D1},
        {7'b0001000, 32'h60000010, 1'b1, 8'h18, 32'h60000092},
        {7'b0000100, 32'h60000010, 1'b1, 8'h0C, 32'h60000097},
        {7'b0000010, 32'h60000010, 1'b1, 8'h08, 32'h60000093},
        {7'b0000001, 32'h60000010, 1'b1, 8'h04, 32'h6000009B},
        {7'b1111111, 32'h60000010, 1'b1, 8'h00, 32'h600000D3},
        {7'b0111000, 32'h60000010, 1'b1, 8'h10, 32'h60000097},
        {7'b0011100, 32'h60000010, 1'b1, 8'h1C, 32'h600000D1},
        {7'b0001110, 32'h60000010, 1'b1, 8'h18, 32'h60000092},
        {7'b0000111, 32'h60000010, 1'b1, 8'h0C, 32'h60000097},
        {7'b0000011, 32'h60000010, 1'b1, 8'h08, 32'h60000093},
        {7'b0001000, 32'h00000093, 1'b0, 8'h00, 32'h00000000},
        {7'b0010000, 32'h00000053, 1'b0, 8'h00, 32'h00000000},
        {7'b0011000, 32'h00000053, 1'b1, 8'h18, 32'h000000D2},
        {7'b0100000, 32'h000000D3, 1'b1, 8'h10, 32'h000000D7},
        {7'b0000001, 32'h00000030, 1'b1, 8'h04, 32'h0000009B},
        {7'b0001000, 32'h00000053, 1'b1, 8'h18, 32'h000000D2}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [6:0] r);
        {req_reset, req_dabort, req_fiq, req_irq, req_pabort, req_swi, req_undef} = r;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: outputs cleared by reset
        chk(new_pc == 0 && new_status == 0 && !entry_pulse && !pc_load && !status_load,
            "R13 reset outputs", {29'd0, entry_pulse, pc_load, status_load}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!entry_pulse && !status_load && saved_status == 0,
            "R13 idle after reset", saved_status, 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < 19; k++) begin
            set_req(VT[k][79:73]);
            cur_status = VT[k][72:41];
            cur_pc     = 32'h1000 + 32'(k) * 4;
            @(negedge clk);
            if (VT[k][40]) begin
                chk(entry_pulse && pc_load && status_load,
                    $sformatf("R9 row %0d pulse", k), {31'd0, entry_pulse}, 1);
                chk(new_pc == {24'd0, VT[k][39:32]},
                    $sformatf("R1/R2/R8 row %0d vector", k), new_pc, {24'd0, VT[k][39:32]});
                chk(new_status == VT[k][31:0],
                    $sformatf("R3/R5/R6 row %0d status", k), new_status, VT[k][31:0]);
                chk(saved_status == VT[k][72:41],
                    $sformatf("R4 row %0d saved", k), saved_status, VT[k][72:41]);
                chk(link_val == cur_pc,
                    $sformatf("R9 row %0d link", k), link_val, cur_pc);
            end else begin
                chk(!entry_pulse && !pc_load,
                    $sformatf("R7 row %0d masked", k), {31'd0, entry_pulse}, 0);
            end
        end

        // R9: pulse lasts one cycle
        set_req(7'b0);
        @(negedge clk);
        chk(!entry_pulse && !pc_load, "R9 pulse falls", {31'd0, entry_pulse}, 0);

        // R4/R10: entry then return from normal-interrupt mode
        set_req(7'b0001000); cur_status = 32'h60000010; cur_pc = 32'h2000;
        @(negedge clk);
        chk(entry_pulse && saved_status == 32'h60000010, "R4 entry before return",
            saved_status, 32'h60000010);
        set_req(7'b0); cur_status = 32'h60000092; ret_cmd = 1; ret_link = 32'hABC0;
        @(negedge clk);
        chk(new_pc == 32'hABC0 && pc_load && status_load && !entry_pulse,
            "R10 return pc", new_pc, 32'hABC0);
        chk(new_status == 32'h60000010, "R10 return status", new_status, 32'h60000010);

        // R10: return ignored in User mode
        cur_status = 32'h00000010;
        @(negedge clk);
        chk(!pc_load && !status_load, "R10 user return ignored",
            {30'd0, pc_load, status_load}, 0);
        ret_cmd = 0;

        // R11: privileged mode write
        cur_status = 32'h600000D3; mode_wr_en = 1; mode_wr_val = 5'b11111;
        @(negedge clk);
        chk(status_load && !pc_load && new_status == 32'h600000DF,
            "R11 mode write", new_status, 32'h600000DF);
        // R11: ignored in User mode
        cur_status = 32'h00000010;
        @(negedge clk);
        chk(!status_load, "R11 user write ignored", {31'd0, status_load}, 0);
        // R11: illegal encoding ignored
        cur_status = 32'h000000D3; mode_wr_val = 5'b00101;
        @(negedge clk);
        chk(!status_load, "R11 illegal mode ignored", {31'd0, status_load}, 0);

        // R12: entry beats return and write
        cur_status = 32'h00000013; mode_wr_val = 5'b11111; ret_cmd = 1;
        ret_link = 32'h5550; set_req(7'b0001000);
        @(negedge clk);
        chk(entry_pulse && new_pc == 32'h18, "R12 entry first", new_pc, 32'h18);
        // R12: return beats write; IRQ copy now holds 0x13
        set_req(7'b0); cur_status = 32'h00000012;
        @(negedge clk);
        chk(new_pc == 32'h5550 && new_status == 32'h00000013 && !entry_pulse,
            "R12 return over write", new_status, 32'h00000013);
        ret_cmd = 0; mode_wr_en = 0;

        // R13: reset mid-run
        set_req(7'b0100000);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(new_pc == 0 && !entry_pulse && saved_status == 0 && link_val == 0,
            "R13 reset mid-run", new_pc, 0);
        set_req(7'b0);
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule